// File: doc/BRIEF.md
# Sequential Five-Step Load-Store RISC Core

A small 32-bit processor that runs one instruction at a time. Each instruction goes through five steps in order: fetch, decode with register read, execute, memory access and write-back. A latch between each pair of steps holds the values passed on: instruction, next pc, both operands, immediate, ALU result, branch condition and load data. Nothing overlaps, so every instruction that is not a halt takes exactly five clock cycles.

The core reads instructions from a word-wide instruction port that answers in the same cycle. It also drives a data port with an address, write data, read data and a one-cycle write strobe. It executes register-register ADD, SUB and signed set-less-than, load word, store word, branch-if-zero, unconditional jump and halt. After a halt it raises a flag and stops fetching until reset. Register 0 is wired to zero.

Top module: `seqrisc_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0, halted_o is 0 and dmem_we_o is 0. Asserting reset again after a run returns the fetch address to 0.
- R2: Encoding: opcode [31:26], rs1 [25:21], rs2 or I-type destination [20:16], R-type destination [15:11], function [10:0], immediate [15:0], jump offset [25:0]; immediate and offset are sign-extended. The register-register opcode is 0x00. Function 0x020 writes rs1+rs2 and function 0x022 writes rs1-rs2 (modulo 2^32) to the destination.
- R3: Function 0x02A writes 1 to the destination when rs1 < rs2 as signed 32-bit values, else 0.
- R4: Opcode 0x23 (load) reads the data word at byte address rs1 + sign-extended immediate and writes it to the register in [20:16].
- R5: Opcode 0x2B (store) writes the register in [20:16] to byte address rs1 + sign-extended immediate. dmem_we_o is high for exactly one cycle per store, in the memory step, and never for any other instruction.
- R6: Opcode 0x04 (branch-if-zero) sets pc to pc+4+immediate when rs1 is zero, and to pc+4 otherwise.
- R7: Opcode 0x02 (jump) sets pc to pc+4+offset.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: Opcode 0x3F (halt) sets halted_o two cycles after its fetch. From then on halted_o stays high and imem_addr_o stays constant.
- R10: The fetch address changes exactly five cycles after the previous fetch. An unknown opcode, or a register-register word with an unknown function, only advances pc by 4.
- R11: A subtractive GCD program built from load, SUB, branch-if-zero, SLT, jump and store leaves gcd(X,Y) in data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Fetch byte address (pc) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |
| dmem_we_o | output | 1 | Data write strobe |
| halted_o | output | 1 | Core has executed a halt |

## Verification
The store strobe and the program counter update belong to the same instruction and both depend on the execute-step latch. A store must write its word exactly once, at the right address, and the following fetch must still go to pc+4. The bench provokes this with runs of back-to-back stores, some with negative displacements. It judges the result from the memory contents, from the total strobe count and from a check that the strobe is never high two cycles in a row. A second case is a register written in write-back and read by the very next instruction, such as a loaded base register used at once for addressing. The memory contents settle that case.

// File: rtl/seqrisc_pkg.sv
`timescale 1ns/1ps
package seqrisc_pkg;
  localparam int XLEN = 32;
  localparam int RF_N = 32;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_J    = 6'h02;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [5:0] OP_HALT = 6'h3F;

  localparam logic [10:0] FN_ADD = 11'h020;
  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_SLT = 11'h02A;

  typedef enum logic [2:0] {
    ST_IF, ST_ID, ST_EX, ST_MM, ST_WB, ST_HALT
  } step_e;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic            is_rr;
    logic            is_lw;
    logic            is_sw;
    logic            is_beqz;
    logic            is_j;
    logic            is_halt;
    alu_op_e         alu_op;
    logic            wr_en;
    logic [4:0]      wr_addr;
    logic [4:0]      rs1;
    logic [4:0]      rs2;
    logic [XLEN-1:0] imm;
  } dec_t;
endpackage

// File: rtl/seqrisc_regfile.sv
`timescale 1ns/1ps
module seqrisc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_a_i,
  input  logic [AW-1:0]   ra_b_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREG];

  // entry 0 is a constant, the rest are flops
  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs[g] <= '0;
      else if (we_i && wa_i == AW'(g))     regs[g] <= wd_i;
    end
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];
endmodule

// File: rtl/seqrisc_alu.sv
`timescale 1ns/1ps
module seqrisc_alu
  import seqrisc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  logic [XLEN-1:0] diff;
  logic            lt;

  assign diff = a_i - b_i;
  // signed less-than from sign bits and difference
  assign lt = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN-1];

  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = diff;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, lt};
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/seqrisc_decode.sv
`timescale 1ns/1ps
module seqrisc_decode
  import seqrisc_pkg::*;
(
  input  logic [31:0] ir_i,
  output dec_t        dec_o
);
  logic [5:0]  opc;
  logic [10:0] fn;

  assign opc = ir_i[31:26];
  assign fn  = ir_i[10:0];

  always_comb begin
    dec_o         = '0;
    dec_o.alu_op  = ALU_ADD;
    dec_o.rs1     = ir_i[25:21];
    dec_o.rs2     = ir_i[20:16];
    dec_o.wr_addr = ir_i[20:16];
    dec_o.imm     = {{(XLEN-16){ir_i[15]}}, ir_i[15:0]};
    unique case (opc)
      OP_RR: begin
        dec_o.wr_addr = ir_i[15:11];
        unique case (fn)
          FN_ADD:  begin dec_o.is_rr = 1'b1; dec_o.alu_op = ALU_ADD; end
          FN_SUB:  begin dec_o.is_rr = 1'b1; dec_o.alu_op = ALU_SUB; end
          FN_SLT:  begin dec_o.is_rr = 1'b1; dec_o.alu_op = ALU_SLT; end
          default: dec_o.is_rr = 1'b0;
        endcase
        dec_o.wr_en = dec_o.is_rr;
      end
      OP_LW: begin
        dec_o.is_lw = 1'b1;
        dec_o.wr_en = 1'b1;
      end
      OP_SW:   dec_o.is_sw   = 1'b1;
      OP_BEQZ: dec_o.is_beqz = 1'b1;
      OP_J: begin
        dec_o.is_j = 1'b1;
        dec_o.imm  = {{(XLEN-26){ir_i[25]}}, ir_i[25:0]};
      end
      OP_HALT: dec_o.is_halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/seqrisc_core.sv
`timescale 1ns/1ps
module seqrisc_core
  import seqrisc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_data_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  input  logic [31:0] dmem_rdata_i,
  output logic        dmem_we_o,
  output logic        halted_o
);
  localparam int RAW = $clog2(RF_N);

  step_e           step_q;
  logic [XLEN-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, aluo_q, lmd_q;
  logic            cond_q;

  dec_t            dec;
  logic [XLEN-1:0] rf_a, rf_b, rf_wd;
  logic            rf_we;
  logic [XLEN-1:0] op_a, op_b, alu_y;

  seqrisc_decode u_dec (
    .ir_i  (ir_q),
    .dec_o (dec)
  );

  seqrisc_regfile #(.XLEN(XLEN), .NREG(RF_N)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (dec.rs1[RAW-1:0]),
    .ra_b_i (dec.rs2[RAW-1:0]),
    .rd_a_o (rf_a),
    .rd_b_o (rf_b),
    .we_i   (rf_we),
    .wa_i   (dec.wr_addr[RAW-1:0]),
    .wd_i   (rf_wd)
  );

  // execute operand select
  always_comb begin
    if (dec.is_rr) begin
      op_a = a_q;
      op_b = b_q;
    end else if (dec.is_beqz || dec.is_j) begin
      op_a = npc_q;
      op_b = imm_q;
    end else begin
      op_a = a_q;
      op_b = imm_q;
    end
  end

  seqrisc_alu #(.XLEN(XLEN)) u_alu (
    .op_i (dec.is_rr ? dec.alu_op : ALU_ADD),
    .a_i  (op_a),
    .b_i  (op_b),
    .y_o  (alu_y)
  );

  assign rf_we = (step_q == ST_WB) && dec.wr_en;
  assign rf_wd = dec.is_lw ? lmd_q : aluo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IF;
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      aluo_q <= '0;
      cond_q <= 1'b0;
      lmd_q  <= '0;
    end else begin
      unique case (step_q)
        ST_IF: begin
          ir_q   <= imem_data_i;
          npc_q  <= pc_q + XLEN'(4);
          step_q <= ST_ID;
        end
        ST_ID: begin
          a_q    <= rf_a;
          b_q    <= rf_b;
          imm_q  <= dec.imm;
          step_q <= dec.is_halt ? ST_HALT : ST_EX;
        end
        ST_EX: begin
          aluo_q <= alu_y;
          cond_q <= dec.is_j || (dec.is_beqz && a_q == '0);
          step_q <= ST_MM;
        end
        ST_MM: begin
          if (dec.is_lw) lmd_q <= dmem_rdata_i;
          step_q <= ST_WB;
        end
        ST_WB: begin
          pc_q   <= cond_q ? aluo_q : npc_q;
          step_q <= ST_IF;
        end
        default: step_q <= ST_HALT;
      endcase
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = aluo_q;
  assign dmem_wdata_o = b_q;
  assign dmem_we_o    = (step_q == ST_MM) && dec.is_sw;
  assign halted_o     = (step_q == ST_HALT);
endmodule

// File: rtl/seqrisc_core_chk.sv
`timescale 1ns/1ps
module seqrisc_core_chk
  import seqrisc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] imem_addr_o,
  input logic        dmem_we_o,
  input logic        halted_o,
  input step_e       step_q
);
  // R5
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |=> !dmem_we_o);

  // R5
  strobe_in_mm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> step_q == ST_MM);

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(imem_addr_o));

  // R10
  pc_moves_after_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(imem_addr_o) |-> $past(step_q) == ST_WB);

  // R10
  fetch_then_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == ST_IF |=> step_q == ST_ID);

  // R9
  halt_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !dmem_we_o);
endmodule

bind seqrisc_core seqrisc_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_o (imem_addr_o),
  .dmem_we_o   (dmem_we_o),
  .halted_o    (halted_o),
  .step_q      (step_q)
);

// File: tb/seqrisc_core_test.sv
`timescale 1ns/1ps
module seqrisc_core_test;
  import seqrisc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted;
  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int checks = 0;
  int errors = 0;
  int we_cnt = 0;
  int we_dbl = 0;

  localparam logic [31:0] HALT_W = {OP_HALT, 26'h0};
  localparam logic [31:0] SENT   = 32'hDEAD_BEEF;

  always #2 clk = ~clk;

  seqrisc_core uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .dmem_we_o    (dmem_we),
    .halted_o     (halted)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] rr(logic [10:0] fn, logic [4:0] rd, logic [4:0] s1, logic [4:0] s2);
    return {OP_RR, s1, s2, rd, fn};
  endfunction
  function automatic logic [31:0] ii(logic [5:0] op, logic [4:0] rd, logic [4:0] s1, logic [15:0] imm);
    return {op, s1, rd, imm};
  endfunction
  function automatic logic [31:0] jj(logic [25:0] off);
    return {OP_J, off};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = HALT_W;
      dmem[i] = SENT;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int max_cyc);
    int n = 0;
    logic prev = 1'b0;
    we_cnt = 0;
    we_dbl = 0;
    do_reset();
    while (!halted && n < max_cyc) begin
      @(negedge clk);
      if (dmem_we) we_cnt++;
      if (dmem_we && prev) we_dbl++;
      prev = dmem_we;
      n++;
    end
    chk("R9 halted after run", {31'b0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'd0);
    chk("R1 halted in reset", {31'b0, halted}, 32'd0);
    chk("R1 strobe in reset", {31'b0, dmem_we}, 32'd0);
  endtask

  task automatic t_alu();
    clear_mem();
    dmem[0] = 32'd7;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'd64;
    imem[0]  = ii(OP_LW, 1, 0, 16'd0);
    imem[1]  = ii(OP_LW, 2, 0, 16'd4);
    imem[2]  = rr(FN_ADD, 3, 1, 2);
    imem[3]  = rr(FN_SUB, 4, 1, 2);
    imem[4]  = rr(FN_SLT, 5, 1, 2);
    imem[5]  = rr(FN_SLT, 6, 2, 1);
    imem[6]  = rr(FN_ADD, 0, 1, 1);
    imem[7]  = ii(OP_LW, 7, 0, 16'd8);
    imem[8]  = ii(OP_SW, 3, 0, 16'd16);
    imem[9]  = ii(OP_SW, 4, 0, 16'd20);
    imem[10] = ii(OP_SW, 5, 0, 16'd24);
    imem[11] = ii(OP_SW, 6, 0, 16'd28);
    imem[12] = ii(OP_SW, 0, 7, 16'hFFFC);
    imem[13] = ii(OP_LW, 8, 7, 16'hFFC0);
    imem[14] = ii(OP_SW, 8, 7, 16'd4);
    imem[15] = rr(FN_SUB, 9, 2, 1);
    imem[16] = ii(OP_SW, 9, 7, 16'd8);
    imem[17] = HALT_W;
    run(400);
    chk("R2 add 7+(-3)", dmem[4], 32'd4);
    chk("R2 sub 7-(-3)", dmem[5], 32'd10);
    chk("R3 slt 7<-3", dmem[6], 32'd0);
    chk("R3 slt -3<7", dmem[7], 32'd1);
    chk("R8 r0 after write", dmem[15], 32'd0);
    chk("R4 load negative displacement", dmem[17], 32'd7);
    chk("R2 sub negative result", dmem[18], 32'hFFFF_FFF6);
    chk("R5 strobe count", we_cnt, 32'd7);
    chk("R5 strobe never two cycles", we_dbl, 32'd0);
    chk("R5 untouched word", dmem[16], SENT);
  endtask

  task automatic t_branch();
    clear_mem();
    dmem[0] = 32'd0;
    dmem[1] = 32'd5;
    imem[0]  = ii(OP_LW, 1, 0, 16'd0);
    imem[1]  = ii(OP_LW, 2, 0, 16'd4);
    imem[2]  = ii(OP_BEQZ, 0, 1, 16'd8);
    imem[3]  = ii(OP_SW, 2, 0, 16'd32);
    imem[4]  = HALT_W;
    imem[5]  = ii(OP_BEQZ, 0, 2, 16'd8);
    imem[6]  = ii(OP_SW, 2, 0, 16'd36);
    imem[7]  = jj(26'd4);
    imem[8]  = ii(OP_SW, 2, 0, 16'd40);
    imem[9]  = ii(OP_SW, 2, 0, 16'd44);
    imem[10] = HALT_W;
    run(400);
    chk("R6 taken branch skips store", dmem[8], SENT);
    chk("R6 not-taken falls through", dmem[9], 32'd5);
    chk("R7 jump skips store", dmem[10], SENT);
    chk("R7 jump target reached", dmem[11], 32'd5);
    chk("R9 halt address", imem_addr, 32'd40);
  endtask

  task automatic t_timing();
    clear_mem();
    imem[0] = {6'h11, 26'h0};
    imem[1] = rr(11'h7FF, 3, 0, 0);
    imem[2] = HALT_W;
    do_reset();
    repeat (4) @(negedge clk);
    chk("R10 pc held four cycles", imem_addr, 32'd0);
    @(negedge clk);
    chk("R10 unknown opcode advances by 4", imem_addr, 32'd4);
    repeat (5) @(negedge clk);
    chk("R10 unknown function advances by 4", imem_addr, 32'd8);
    @(negedge clk);
    chk("R9 halted not yet", {31'b0, halted}, 32'd0);
    @(negedge clk);
    chk("R9 halted two cycles after fetch", {31'b0, halted}, 32'd1);
    repeat (8) @(negedge clk);
    chk("R9 fetch stopped", imem_addr, 32'd8);
    chk("R9 halted stays", {31'b0, halted}, 32'd1);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset returns pc", imem_addr, 32'd0);
  endtask

  task automatic t_gcd(input logic [31:0] x, input logic [31:0] y, input logic [31:0] g);
    clear_mem();
    dmem[0] = x;
    dmem[1] = y;
    imem[0]  = ii(OP_LW, 1, 0, 16'd0);
    imem[1]  = ii(OP_LW, 2, 0, 16'd4);
    imem[2]  = rr(FN_SUB, 3, 1, 2);
    imem[3]  = ii(OP_BEQZ, 0, 3, 16'd24);
    imem[4]  = rr(FN_SLT, 4, 1, 2);
    imem[5]  = ii(OP_BEQZ, 0, 4, 16'd8);
    imem[6]  = rr(FN_SUB, 2, 2, 1);
    imem[7]  = jj(26'h3FFFFE8);
    imem[8]  = rr(FN_SUB, 1, 1, 2);
    imem[9]  = jj(26'h3FFFFE0);
    imem[10] = ii(OP_SW, 1, 0, 16'd20);
    imem[11] = HALT_W;
    run(20000);
    chk("R11 gcd result", dmem[5], g);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_branch();
    t_timing();
    t_gcd(32'd36, 32'd24, 32'd12);
    t_gcd(32'd17, 32'd5, 32'd1);
    t_gcd(32'd9, 32'd9, 32'd9);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule